// File: doc/BRIEF.md
# Register-to-Register ALU with Legacy Flag Mode

This block is the register-group arithmetic/logic unit of a small 8-bit machine. It holds sixteen general registers. On an execute strobe, it reads two of them (X and Y), applies the operation chosen by a 4-bit sub-opcode, and writes the result back to X. Register 15 is an ordinary register and also the flag register. Operations that produce a carry, borrow or shifted-out bit write that bit to register 15. The result and the flag both land on the clock edge that samples the strobe.

A static `legacy` input selects between two behaviours. In legacy mode, the four logical operations (copy, OR, AND, XOR) clear register 15 after writing their result, and both shifts take register Y as their source while still writing to X. In modern mode, the logical operations leave register 15 alone and the shifts work on X in place.

Code outside the block preloads registers through a simple write port and observes them through a combinational read port. Any sub-opcode outside the supported set changes nothing and is reported with a one-cycle error pulse.

Top module: `reg_alu`

## Requirements
- R1: Sub-opcode 0x0 writes Y to X, 0x1 writes X OR Y, 0x2 writes X AND Y, and 0x3 writes X XOR Y.
- R2: Sub-opcode 0x4 writes the 8-bit wrapped sum X+Y to X and sets register 15 to 1 on carry out, otherwise 0.
- R3: Sub-opcode 0x5 writes X−Y and sub-opcode 0x7 writes Y−X, both wrapped to 8 bits. Register 15 becomes 1 when no borrow occurs (minuend ≥ subtrahend) and 0 when a borrow occurs.
- R4: Sub-opcode 0x6 writes source>>1 to X and puts the source LSB in register 15. Sub-opcode 0xE writes source<<1 to X and puts the source MSB in register 15.
- R5: With `legacy`=1, sub-opcodes 0x0–0x3 leave register 15 at 0. With `legacy`=0 they leave register 15 unchanged (unless X is 15).
- R6: With `legacy`=1, the shift source is register Y. With `legacy`=0 it is register X. The result always goes to X, and Y is not modified (unless Y equals X or 15).
- R7: When X is 15 and the operation produces a flag, register 15 ends up holding the flag, not the result.
- R8: An execute with any sub-opcode other than 0x0–0x7 and 0xE changes no register and drives `bad_op` high for exactly the one cycle after the sampling edge.
- R9: Synchronous reset clears all registers to zero and `bad_op` to 0. With neither `exec` nor `wr_en` high, no register changes.
- R10: `rd_data` always shows the register selected by `rd_sel`. A `wr_en` without `exec` loads `wr_data` into register `wr_sel` on the next edge, and `exec` takes priority when both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| exec | input | 1 | Execute strobe for one ALU operation |
| legacy | input | 1 | Static mode select: 1 legacy, 0 modern |
| op | input | 4 | Sub-opcode |
| sel_x | input | 4 | Register X index (source and destination) |
| sel_y | input | 4 | Register Y index (source) |
| wr_en | input | 1 | Direct register write enable |
| wr_sel | input | 4 | Direct write register index |
| wr_data | input | 8 | Direct write data |
| rd_sel | input | 4 | Read port register index |
| rd_data | output | 8 | Read port data |
| bad_op | output | 1 | One-cycle pulse after an unsupported sub-opcode |

## Verification
The bench builds the block with its default parameters: an 8-bit data width and sixteen registers. With these values, the carry and borrow edges sit at 0xFF/0x00, and the flag register is index 15, so register-overlap cases such as X equal to 15 can be driven directly. Directed values reach the carry, borrow and equal-operand boundaries and the LSB and MSB shift-out cases in both modes. They also reach an unsupported sub-opcode, whose register file is compared before and after the strobe.

// File: rtl/reg_alu.sv
module reg_alu #(
  parameter int DW = 8,
  parameter int NR = 16,
  parameter int SW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          exec,
  input  logic          legacy,
  input  logic [3:0]    op,
  input  logic [SW-1:0] sel_x,
  input  logic [SW-1:0] sel_y,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [SW-1:0] rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          bad_op
);
  localparam int FLAG = NR - 1;

  logic [NR-1:0][DW-1:0] regs;
  logic [DW-1:0] a, b, src, res;
  logic [DW:0]   sum, d_xy, d_yx;
  logic          flg, flg_en, illegal;

  assign a    = regs[sel_x];
  assign b    = regs[sel_y];
  assign src  = legacy ? b : a;
  assign sum  = {1'b0, a} + {1'b0, b};
  assign d_xy = {1'b0, a} - {1'b0, b};
  assign d_yx = {1'b0, b} - {1'b0, a};
  assign rd_data = regs[rd_sel];

  always_comb begin
    res = '0;
    flg = 1'b0;
    flg_en = 1'b0;
    illegal = 1'b0;
    case (op)
      4'h0: begin res = b;     flg_en = legacy; end
      4'h1: begin res = a | b; flg_en = legacy; end
      4'h2: begin res = a & b; flg_en = legacy; end
      4'h3: begin res = a ^ b; flg_en = legacy; end
      4'h4: begin res = sum[DW-1:0];  flg = sum[DW];   flg_en = 1'b1; end
      4'h5: begin res = d_xy[DW-1:0]; flg = !d_xy[DW]; flg_en = 1'b1; end
      4'h7: begin res = d_yx[DW-1:0]; flg = !d_yx[DW]; flg_en = 1'b1; end
      4'h6: begin res = src >> 1; flg = src[0];    flg_en = 1'b1; end
      4'hE: begin res = src << 1; flg = src[DW-1]; flg_en = 1'b1; end
      default: illegal = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regs   <= '0;
      bad_op <= 1'b0;
    end else begin
      bad_op <= exec && illegal;
      if (exec) begin
        if (!illegal) begin
          regs[sel_x] <= res;
          if (flg_en) regs[FLAG] <= {{(DW-1){1'b0}}, flg};
        end
      end else if (wr_en) begin
        regs[wr_sel] <= wr_data;
      end
    end
  end

  assert_bad_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    bad_op |=> !bad_op);
  assert_bad_nowrite_R8: assert property (@(posedge clk) disable iff (rst)
    (exec && illegal) |=> (regs == $past(regs)) && bad_op);
  assert_flag_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (exec && (op == 4'h4 || op == 4'h5 || op == 4'h7 || op == 4'h6 || op == 4'hE))
      |=> (regs[FLAG] <= 1));
  assert_legacy_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (exec && legacy && op <= 4'h3) |=> (regs[FLAG] == '0));
  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!exec && !wr_en) |=> $stable(regs));
endmodule

// File: tb/sim_reg_alu.sv
module sim_reg_alu;
  logic clk = 0, rst = 1, exec = 0, legacy = 0, wr_en = 0;
  logic [3:0] op = 0, sel_x = 0, sel_y = 0, wr_sel = 0, rd_sel = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic bad_op;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  reg_alu u0 (.clk, .rst, .exec, .legacy, .op, .sel_x, .sel_y, .wr_en,
              .wr_sel, .wr_data, .rd_sel, .rd_data, .bad_op);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic ld(input logic [3:0] r, input logic [7:0] v);
    @(negedge clk); wr_en = 1; wr_sel = r; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rdchk(input string req, input logic [3:0] r, input logic [7:0] exp);
    rd_sel = r; #1; chk(req, rd_data, exp);
  endtask

  task automatic ex(input logic lg, input logic [3:0] o, input logic [3:0] x, input logic [3:0] y);
    @(negedge clk); legacy = lg; op = o; sel_x = x; sel_y = y; exec = 1;
    @(negedge clk); exec = 0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 16; i++) rdchk("R9 reset", 4'(i), 8'h00);
    chk("R9 bad_op reset", {7'b0, bad_op}, 8'h00);
  endtask

  task automatic t_logic_modern;
    ld(15, 8'h77); ld(1, 8'hC3); ld(2, 8'h5A);
    rdchk("R10 load", 1, 8'hC3);
    ex(0, 4'h1, 1, 2); rdchk("R1 or", 1, 8'hDB); rdchk("R5 modern keeps flag", 15, 8'h77);
    ld(1, 8'hC3); ex(0, 4'h2, 1, 2); rdchk("R1 and", 1, 8'h42);
    ld(1, 8'hC3); ex(0, 4'h3, 1, 2); rdchk("R1 xor", 1, 8'h99);
    ex(0, 4'h0, 1, 2); rdchk("R1 copy", 1, 8'h5A);
    rdchk("R5 modern keeps flag", 15, 8'h77);
  endtask

  task automatic t_add;
    ld(3, 8'hF0); ld(4, 8'h20); ex(0, 4'h4, 3, 4);
    rdchk("R2 add wrap", 3, 8'h10); rdchk("R2 carry", 15, 8'h01);
    ex(0, 4'h4, 3, 4);
    rdchk("R2 add", 3, 8'h30); rdchk("R2 no carry", 15, 8'h00);
  endtask

  task automatic t_sub;
    ld(3, 8'h10); ld(4, 8'h20); ex(0, 4'h5, 3, 4);
    rdchk("R3 x-y wrap", 3, 8'hF0); rdchk("R3 borrow", 15, 8'h00);
    ld(3, 8'h10); ex(0, 4'h7, 3, 4);
    rdchk("R3 y-x", 3, 8'h10); rdchk("R3 no borrow", 15, 8'h01);
    ld(3, 8'h20); ld(15, 8'h00); ex(0, 4'h5, 3, 4);
    rdchk("R3 equal", 3, 8'h00); rdchk("R3 equal flag", 15, 8'h01);
  endtask

  task automatic t_shift_modern;
    ld(5, 8'h81); ld(6, 8'h3C); ex(0, 4'h6, 5, 6);
    rdchk("R4 shr", 5, 8'h40); rdchk("R4 shr lsb", 15, 8'h01);
    ld(5, 8'h81); ex(0, 4'hE, 5, 6);
    rdchk("R4 shl", 5, 8'h02); rdchk("R4 shl msb", 15, 8'h01);
    ld(5, 8'h42); ex(0, 4'h6, 5, 6);
    rdchk("R4 shr", 5, 8'h21); rdchk("R4 shr lsb0", 15, 8'h00);
    rdchk("R6 modern y untouched", 6, 8'h3C);
  endtask

  task automatic t_legacy;
    ld(15, 8'h77); ld(1, 8'h0F); ld(2, 8'hF0); ex(1, 4'h1, 1, 2);
    rdchk("R5 legacy or", 1, 8'hFF); rdchk("R5 legacy clears", 15, 8'h00);
    ld(5, 8'h01); ld(6, 8'h80); ex(1, 4'h6, 5, 6);
    rdchk("R6 legacy shr src y", 5, 8'h40); rdchk("R6 legacy shr flag", 15, 8'h00);
    rdchk("R6 y untouched", 6, 8'h80);
    ld(5, 8'h01); ex(1, 4'hE, 5, 6);
    rdchk("R6 legacy shl src y", 5, 8'h00); rdchk("R6 legacy shl flag", 15, 8'h01);
  endtask

  task automatic t_x15;
    ld(15, 8'h05); ld(4, 8'h0A); ex(0, 4'h1, 15, 4);
    rdchk("R7 modern or into 15", 15, 8'h0F);
    ex(0, 4'h4, 15, 4);
    rdchk("R7 flag wins", 15, 8'h00);
    ld(15, 8'hFF); ld(4, 8'h01); ex(0, 4'h4, 15, 4);
    rdchk("R7 flag wins carry", 15, 8'h01);
  endtask

  task automatic t_illegal;
    logic [7:0] snap [16];
    for (int i = 0; i < 16; i++) begin rd_sel = 4'(i); #1; snap[i] = rd_data; end
    @(negedge clk); legacy = 0; op = 4'h8; sel_x = 3; sel_y = 4; exec = 1;
    @(negedge clk); exec = 0;
    chk("R8 pulse high", {7'b0, bad_op}, 8'h01);
    @(negedge clk);
    chk("R8 pulse one cycle", {7'b0, bad_op}, 8'h00);
    for (int i = 0; i < 16; i++) rdchk("R8 no write", 4'(i), snap[i]);
    repeat (3) @(negedge clk);
    rdchk("R9 idle stable", 3, snap[3]);
  endtask

  task automatic t_priority;
    @(negedge clk); ld(7, 8'h11); ld(8, 8'h22);
    legacy = 0; op = 4'h0; sel_x = 7; sel_y = 8; exec = 1;
    wr_en = 1; wr_sel = 7; wr_data = 8'hEE;
    @(negedge clk); exec = 0; wr_en = 0;
    rdchk("R10 exec priority", 7, 8'h22);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset; t_logic_modern; t_add; t_sub; t_shift_modern;
    t_legacy; t_x15; t_illegal; t_priority;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule